// File: doc/BRIEF.md
# Integer Load Execution Unit

This unit carries out the scalar integer load operations of a 64-bit register machine, one at a time. A decoded operation arrives with a base register index and value, a 16-bit displacement, a size code, an extension flag, an update flag, a displacement-scaling flag and a destination index. The unit forms the effective address and places a single read request on the memory side, carrying the address and a byte count. It then takes the returned word and widens it to 64 bits, either with zeros or with copies of its top bit.

Memory hands back the addressed bytes already moved into the low byte lanes of a 64-bit word. The unit presents the destination value and destination index in a one-cycle result pulse. In the same cycle it presents the base-register writeback, which carries the effective address and is used by update forms. An update form whose base index is zero or equal to its destination index is refused. It produces no memory traffic and raises a one-cycle illegal pulse instead.

Top module: `ld_exec_unit`

## Requirements
- R1: For a non-update operation with base index 0, the base is taken as zero whatever value is on the base value input. For any other non-update operation, the base is the base value input.
- R2: An accepted update operation with a legal index pair uses the base value input as its base. Its result pulse carries res_wb_en=1, res_wb_idx equal to the base index and res_wb_data equal to the effective address.
- R3: When op_ds is 0, the effective address is the base plus the 16-bit displacement sign-extended to 64 bits.
- R4: When op_ds is 1, the effective address is the base plus displacement bits 13:0 followed by two zero bits, sign-extended from displacement bit 13. Displacement bits 15:14 are ignored in this case.
- R5: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. This count appears on mem_req_bytes.
- R6: With op_sext=0, a 1-, 2- or 4-byte load returns the low 8, 16 or 32 bits of the response data with all upper bits zero.
- R7: With op_sext=1, a 2- or 4-byte load returns the low 16 or 32 response bits sign-extended from bit 15 or 31. A 1-byte load is extended the same way from bit 7.
- R8: An 8-byte load returns the response word unchanged, whatever the value of op_sext.
- R9: An update operation whose base index is 0 or equals its destination index raises res_illegal for exactly the cycle after acceptance. No memory request is issued for it and res_valid stays low.
- R10: op_ready is high only while the unit is idle. mem_req_valid rises the cycle after acceptance and holds, with a stable address, until mem_req_ready is sampled high. mem_rsp_ready is then high until a response is taken. res_valid is a one-cycle pulse in the cycle after the response is taken.
- R11: A non-update operation never raises res_wb_en. res_valid and res_illegal are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken when op_valid is high |
| op_base_idx | input | 5 | Base register index |
| op_base_val | input | 64 | Base register contents |
| op_disp | input | 16 | Displacement field |
| op_ds | input | 1 | Displacement is scaled by four (bits 13:0 used) |
| op_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| op_sext | input | 1 | Sign-extend the loaded value |
| op_update | input | 1 | Write the effective address back to the base register |
| op_dst_idx | input | 5 | Destination register index |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Effective address |
| mem_req_bytes | output | 4 | Byte count (1, 2, 4 or 8) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 64 | Read data, addressed bytes in the low lanes |
| res_valid | output | 1 | Result pulse |
| res_data | output | 64 | Destination value |
| res_dst_idx | output | 5 | Destination index |
| res_wb_en | output | 1 | Base writeback enable |
| res_wb_idx | output | 5 | Base writeback index |
| res_wb_data | output | 64 | Base writeback value (effective address) |
| res_illegal | output | 1 | Illegal update form pulse |

## Verification
The request is due one cycle after the operation is taken, and it persists for as long as memory holds back its ready. The result pulse comes exactly one cycle after the response handshake, and the illegal pulse comes exactly one cycle after a refused operation is taken. The bench keeps a behavioural phase model that steps on the same rising edges from the same inputs. Each falling edge it compares every output against that model: handshake lines always, address and byte count while a request is expected, and data and writeback fields in the result cycle. Memory ready and response timing are varied from cycle to cycle, which exercises stalls of different lengths.

// File: rtl/ld_exec_pkg.sv
package ld_exec_pkg;
  localparam int XLEN_DEF   = 64;
  localparam int IDX_W_DEF  = 5;
  localparam int DISP_W_DEF = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_DONE = 2'd3
  } ld_state_e;
endpackage

// File: rtl/ld_rst_sync.sv
module ld_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ld_ea_calc.sv
module ld_ea_calc #(
  parameter int XLEN   = ld_exec_pkg::XLEN_DEF,
  parameter int IDX_W  = ld_exec_pkg::IDX_W_DEF,
  parameter int DISP_W = ld_exec_pkg::DISP_W_DEF
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              ds_form,
  input  logic              update,
  output logic [XLEN-1:0]   ea
);
  localparam int DS_W = DISP_W - 2;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] offs;

  always_comb begin
    // index zero means constant zero, but only without writeback
    if (!update && (base_idx == '0)) base_eff = '0;
    else                             base_eff = base_val;

    if (ds_form)
      offs = {{(XLEN-DISP_W){disp[DS_W-1]}}, disp[DS_W-1:0], 2'b00};
    else
      offs = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};

    ea = base_eff + offs;
  end
endmodule

// File: rtl/ld_result_fmt.sv
module ld_result_fmt #(
  parameter int XLEN = ld_exec_pkg::XLEN_DEF
) (
  input  logic [XLEN-1:0]        raw,
  input  ld_exec_pkg::ld_size_e  size,
  input  logic                   sext,
  output logic [XLEN-1:0]        data
);
  import ld_exec_pkg::*;

  localparam int NLANE = XLEN / 8;

  logic [3:0] nbytes;
  logic       top_bit;
  logic       fill;

  always_comb begin
    nbytes = 4'd1 << size;
    case (size)
      SZ_BYTE: top_bit = raw[7];
      SZ_HALF: top_bit = raw[15];
      SZ_WORD: top_bit = raw[31];
      default: top_bit = raw[XLEN-1];
    endcase
    fill = sext && top_bit && (size != SZ_DBL);
  end

  for (genvar lane = 0; lane < NLANE; lane++) begin : g_lane
    always_comb begin
      if (lane < int'(nbytes)) data[lane*8 +: 8] = raw[lane*8 +: 8];
      else                     data[lane*8 +: 8] = {8{fill}};
    end
  end
endmodule

// File: rtl/ld_ctrl.sv
module ld_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_fire,
  input  logic                   op_bad,
  input  logic                   req_ready,
  input  logic                   rsp_valid,
  output ld_exec_pkg::ld_state_e state,
  output logic                   rsp_fire
);
  import ld_exec_pkg::*;

  ld_state_e state_d;
  ld_state_e state_q;

  always_comb begin
    state_d  = state_q;
    rsp_fire = 1'b0;
    case (state_q)
      ST_IDLE: if (op_fire) state_d = op_bad ? ST_DONE : ST_REQ;
      ST_REQ:  if (req_ready) state_d = ST_RSP;
      ST_RSP:  if (rsp_valid) begin
                 state_d  = ST_DONE;
                 rsp_fire = 1'b1;
               end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ld_exec_unit.sv
module ld_exec_unit #(
  parameter int XLEN   = ld_exec_pkg::XLEN_DEF,
  parameter int IDX_W  = ld_exec_pkg::IDX_W_DEF,
  parameter int DISP_W = ld_exec_pkg::DISP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [IDX_W-1:0]  op_base_idx,
  input  logic [XLEN-1:0]   op_base_val,
  input  logic [DISP_W-1:0] op_disp,
  input  logic              op_ds,
  input  logic [1:0]        op_size,
  input  logic              op_sext,
  input  logic              op_update,
  input  logic [IDX_W-1:0]  op_dst_idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [3:0]        mem_req_bytes,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_data,
  output logic [IDX_W-1:0]  res_dst_idx,
  output logic              res_wb_en,
  output logic [IDX_W-1:0]  res_wb_idx,
  output logic [XLEN-1:0]   res_wb_data,
  output logic              res_illegal
);
  import ld_exec_pkg::*;

  logic            rst_n_s;
  ld_state_e       state;
  logic            op_fire;
  logic            op_bad;
  logic            rsp_fire;
  logic [XLEN-1:0] ea_c;
  logic [XLEN-1:0] fmt_c;

  // latched operation
  logic [XLEN-1:0]  ea_q,   ea_d;
  ld_size_e         size_q, size_d;
  logic             sext_q, sext_d;
  logic             upd_q,  upd_d;
  logic             bad_q,  bad_d;
  logic [IDX_W-1:0] bidx_q, bidx_d;
  logic [IDX_W-1:0] didx_q, didx_d;
  logic [XLEN-1:0]  data_q, data_d;

  ld_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ld_ea_calc #(.XLEN(XLEN), .IDX_W(IDX_W), .DISP_W(DISP_W)) u_ea (
    .base_idx (op_base_idx),
    .base_val (op_base_val),
    .disp     (op_disp),
    .ds_form  (op_ds),
    .update   (op_update),
    .ea       (ea_c)
  );

  ld_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .op_fire   (op_fire),
    .op_bad    (op_bad),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .state     (state),
    .rsp_fire  (rsp_fire)
  );

  ld_result_fmt #(.XLEN(XLEN)) u_fmt (
    .raw  (mem_rsp_data),
    .size (size_q),
    .sext (sext_q),
    .data (fmt_c)
  );

  assign op_ready = (state == ST_IDLE);
  assign op_fire  = op_valid && op_ready;
  assign op_bad   = op_update && ((op_base_idx == '0) || (op_base_idx == op_dst_idx));

  // next-state for the operation and result registers
  always_comb begin
    ea_d   = ea_q;
    size_d = size_q;
    sext_d = sext_q;
    upd_d  = upd_q;
    bad_d  = bad_q;
    bidx_d = bidx_q;
    didx_d = didx_q;
    data_d = data_q;
    if (op_fire) begin
      ea_d   = ea_c;
      size_d = ld_size_e'(op_size);
      sext_d = op_sext;
      upd_d  = op_update;
      bad_d  = op_bad;
      bidx_d = op_base_idx;
      didx_d = op_dst_idx;
    end
    if (rsp_fire) data_d = fmt_c;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ea_q   <= '0;
      size_q <= SZ_BYTE;
      sext_q <= 1'b0;
      upd_q  <= 1'b0;
      bad_q  <= 1'b0;
      bidx_q <= '0;
      didx_q <= '0;
      data_q <= '0;
    end else begin
      ea_q   <= ea_d;
      size_q <= size_d;
      sext_q <= sext_d;
      upd_q  <= upd_d;
      bad_q  <= bad_d;
      bidx_q <= bidx_d;
      didx_q <= didx_d;
      data_q <= data_d;
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_bytes = 4'd1 << size_q;
  assign mem_rsp_ready = (state == ST_RSP);

  assign res_valid   = (state == ST_DONE) && !bad_q;
  assign res_illegal = (state == ST_DONE) && bad_q;
  assign res_data    = data_q;
  assign res_dst_idx = didx_q;
  assign res_wb_en   = res_valid && upd_q;
  assign res_wb_idx  = bidx_q;
  assign res_wb_data = ea_q;
endmodule

// File: rtl/ld_exec_unit_chk.sv
module ld_exec_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic [3:0]       mem_req_bytes,
  input logic             mem_rsp_ready,
  input logic             res_valid,
  input logic             res_dst_idx_nz,
  input logic             res_wb_en,
  input logic             res_wb_ok,
  input logic             res_illegal
);
  // R10: request waits, unchanged, for memory to take it
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: idle and busy handshakes never overlap
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!mem_req_valid && !mem_rsp_ready && !res_valid && !res_illegal));

  // R10: result is a single-cycle pulse
  a_r10_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: illegal pulse is a single cycle, followed by idle
  a_r9_ill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |=> (!res_illegal && op_ready));

  // R5: byte count is a single power of two
  a_r5_bytes_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_bytes) == 1 && !mem_req_bytes[3:0] == 1'b0));

  // R11: result and illegal pulses are exclusive
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_illegal));

  // R2: writeback only for a legal base index
  a_r2_wb_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_wb_en |-> (res_valid && res_wb_ok && (res_dst_idx_nz || !res_dst_idx_nz)));
endmodule

bind ld_exec_unit ld_exec_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_ready       (op_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_bytes  (mem_req_bytes),
  .mem_rsp_ready  (mem_rsp_ready),
  .res_valid      (res_valid),
  .res_dst_idx_nz (res_dst_idx != '0),
  .res_wb_en      (res_wb_en),
  .res_wb_ok      ((res_wb_idx != '0) && (res_wb_idx != res_dst_idx)),
  .res_illegal    (res_illegal)
);

// File: tb/ld_exec_unit_test.sv
module ld_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [4:0]  op_base_idx = '0;
  logic [63:0] op_base_val = '0;
  logic [15:0] op_disp = '0;
  logic        op_ds = 1'b0;
  logic [1:0]  op_size = '0;
  logic        op_sext = 1'b0;
  logic        op_update = 1'b0;
  logic [4:0]  op_dst_idx = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [3:0]  mem_req_bytes;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [63:0] res_data;
  logic [4:0]  res_dst_idx;
  logic        res_wb_en;
  logic [4:0]  res_wb_idx;
  logic [63:0] res_wb_data;
  logic        res_illegal;

  always #2 clk = ~clk;

  ld_exec_unit uut (.*);

  int errors = 0;
  int checks = 0;
  bit mem_on = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 request, 2 await data, 3 result
  int          m_phase = 0;
  bit          m_bad, m_upd, m_ds, m_zero_base;
  logic [63:0] m_ea, m_res;
  logic [1:0]  m_size;
  bit          m_sext;
  logic [4:0]  m_bidx, m_didx;

  function automatic logic [63:0] ref_ea(logic [4:0] bi, logic [63:0] bv,
                                         logic [15:0] d, bit ds, bit upd);
    logic [63:0] b;
    logic [63:0] o;
    b = (!upd && bi == 0) ? 64'd0 : bv;
    if (ds) o = {{48{d[13]}}, d[13:0], 2'b00};
    else    o = {{48{d[15]}}, d};
    return b + o;
  endfunction

  function automatic logic [63:0] ref_fmt(logic [63:0] r, logic [1:0] sz, bit sx);
    case (sz)
      2'd0: return sx ? {{56{r[7]}},  r[7:0]}  : {56'd0, r[7:0]};
      2'd1: return sx ? {{48{r[15]}}, r[15:0]} : {48'd0, r[15:0]};
      2'd2: return sx ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_phase = 0;
    else case (m_phase)
      0: if (op_valid) begin
           m_bad  = op_update && (op_base_idx == 0 || op_base_idx == op_dst_idx);
           m_upd  = op_update; m_ds = op_ds; m_size = op_size; m_sext = op_sext;
           m_bidx = op_base_idx; m_didx = op_dst_idx;
           m_zero_base = !op_update && op_base_idx == 0;
           m_ea   = ref_ea(op_base_idx, op_base_val, op_disp, op_ds, op_update);
           m_phase = m_bad ? 3 : 1;
         end
      1: if (mem_req_ready) m_phase = 2;
      2: if (mem_rsp_valid) begin
           m_res = ref_fmt(mem_rsp_data, m_size, m_sext);
           m_phase = 3;
         end
      default: m_phase = 0;
    endcase
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 op_ready", 64'(op_ready), 64'(m_phase == 0));
      chk("R10 mem_req_valid", 64'(mem_req_valid), 64'(m_phase == 1 && !m_bad));
      chk("R10 mem_rsp_ready", 64'(mem_rsp_ready), 64'(m_phase == 2));
      chk("R10 res_valid", 64'(res_valid), 64'(m_phase == 3 && !m_bad));
      chk("R9 res_illegal", 64'(res_illegal), 64'(m_phase == 3 && m_bad));
      if (m_phase == 1) begin
        chk(m_zero_base ? "R1 addr" : (m_ds ? "R4 addr" : "R3 addr"), mem_req_addr, m_ea);
        chk("R5 bytes", 64'(mem_req_bytes), 64'(4'd1 << m_size));
      end
      if (m_phase == 3 && !m_bad) begin
        chk(m_size == 3 ? "R8 data" : (m_sext ? "R7 data" : "R6 data"), res_data, m_res);
        chk("R10 dst_idx", 64'(res_dst_idx), 64'(m_didx));
        chk(m_upd ? "R2 wb_en" : "R11 wb_en", 64'(res_wb_en), 64'(m_upd));
        if (m_upd) begin
          chk("R2 wb_idx", 64'(res_wb_idx), 64'(m_bidx));
          chk("R2 wb_data", res_wb_data, m_ea);
        end
      end
    end
  end

  // memory side: varying stalls
  initial begin
    forever begin
      @(negedge clk);
      if (mem_on) begin
        mem_req_ready = ($urandom % 3) != 0;
        mem_rsp_valid = ($urandom % 3) != 0;
        mem_rsp_data  = {$urandom, $urandom};
      end
    end
  end

  task automatic issue(logic [4:0] bi, logic [63:0] bv, logic [15:0] d, bit ds,
                       logic [1:0] sz, bit sx, bit upd, logic [4:0] di);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_base_idx = bi; op_base_val = bv; op_disp = d; op_ds = ds;
    op_size = sz; op_sext = sx; op_update = upd; op_dst_idx = di;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_all();
    // R1: non-update, index zero ignores the base value
    issue(5'd0, 64'hDEAD_BEEF_0000_1000, 16'h0010, 1'b0, 2'd0, 1'b0, 1'b0, 5'd3);
    // R3: negative displacement
    issue(5'd4, 64'h0000_0000_0001_0000, 16'hFFF0, 1'b0, 2'd1, 1'b0, 1'b0, 5'd5);
    // R4: scaled displacement, top bits set but ignored, bit 13 negative
    issue(5'd6, 64'h0000_0000_0002_0000, 16'hE001, 1'b1, 2'd3, 1'b0, 1'b0, 5'd7);
    issue(5'd6, 64'h0000_0000_0002_0000, 16'hC7FF, 1'b1, 2'd2, 1'b1, 1'b0, 5'd8);
    // R7 and R6: halfword and word extension
    issue(5'd2, 64'h100, 16'h0002, 1'b0, 2'd1, 1'b1, 1'b0, 5'd9);
    issue(5'd2, 64'h100, 16'h0004, 1'b0, 2'd2, 1'b0, 1'b0, 5'd9);
    // R8: doubleword with sign flag set
    issue(5'd2, 64'h100, 16'h0008, 1'b0, 2'd3, 1'b1, 1'b0, 5'd9);
    // R2: legal update form
    issue(5'd3, 64'h0000_0000_0000_4000, 16'h0020, 1'b0, 2'd0, 1'b0, 1'b1, 5'd4);
    issue(5'd3, 64'h0000_0000_0000_4000, 16'h0008, 1'b1, 2'd3, 1'b0, 1'b1, 5'd1);
    // R9: illegal update forms
    issue(5'd0, 64'h55, 16'h0001, 1'b0, 2'd0, 1'b0, 1'b1, 5'd2);
    issue(5'd7, 64'h55, 16'h0001, 1'b0, 2'd2, 1'b0, 1'b1, 5'd7);
    for (int i = 0; i < 300; i++) begin
      issue(5'($urandom % 4), {$urandom, $urandom}, 16'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom), 5'($urandom % 4));
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    bit timeout = 1'b0;
    repeat (4) @(negedge clk);
    // reset state, R10
    chk("R10 reset req", 64'(mem_req_valid), 64'd0);
    chk("R10 reset res", 64'(res_valid | res_illegal), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mem_on = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule